// File: doc/BRIEF.md
# Index-Based Syndrome Coder

This block stores one key bit as a helper index instead of an algebraic parity word. When a bit is provisioned, a group of signed, real-valued device responses streams in one per cycle. The block returns the position of the largest response when the bit is 1, or the position of the smallest when the bit is 0. That position is the syndrome. At regeneration the same group streams in again along with the stored position. The block picks the response at that position and returns its polarity as the recovered bit. Because the chosen response sits at an extreme of the group, it keeps its sign under noise.

A configuration input sets how many candidates form a group: a half-width group (16 positions for a 5-bit index), a five-quarter group (20 positions in a 5-bit index) or the full index range (32). The configuration is captured once when a job is accepted. Equal responses are resolved by a random bit that the caller supplies with each response.

Top module: `isc_coder`

## Requirements
- R1: After synchronous reset the block is idle: start_ready is 1, resp_ready is 0 and out_valid is 0.
- R2: In provision mode (start_mode = 0) with start_bit = 1, out_index is the position of the largest response in the group.
- R3: In provision mode with start_bit = 0, out_index is the position of the smallest response in the group.
- R4: Responses are compared as two's-complement signed values over their full width, so a large negative value is smaller than a small positive one.
- R5: start_cfg selects the group size: 00 gives 2^(IDX_W-1) responses (16), 01 gives 5·2^(IDX_W-3) (20), and 10 or 11 give 2^IDX_W (32). Exactly that many responses are accepted, at positions 0 upward, and no provisioned index reaches the group size.
- R6: When a response equals the current best, it replaces the best only if tie_rnd, which is sampled with that response, is 1.
- R7: In regeneration mode (start_mode = 1), out_bit is 1 when the response at position start_index is not negative and 0 when it is negative. out_index repeats start_index.
- R8: In regeneration mode, a start_index at or beyond the group size gives out_bit = 0.
- R9: out_valid rises in the cycle after the last response handshake. out_index and out_bit are held until out_ready is seen, and the block then returns to idle.
- R10: start_cfg is sampled only when a job is accepted. Changing it during a scan does not change the number of responses taken.
- R11: In provision mode, out_bit returns the stored data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Job request |
| start_ready | output | 1 | Block idle, job can be accepted |
| start_mode | input | 1 | 0 provision, 1 regenerate |
| start_bit | input | 1 | Key bit to store (provision) |
| start_cfg | input | 2 | Group-size select |
| start_index | input | IDX_W | Stored syndrome index (regenerate) |
| resp_valid | input | 1 | Response available |
| resp_ready | output | 1 | Block is scanning a group |
| resp_data | input | RESP_W | Signed device response |
| tie_rnd | input | 1 | Random bit for equal comparisons |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result consumed |
| out_index | output | IDX_W | Syndrome index or echoed index |
| out_bit | output | 1 | Recovered or echoed bit |

## Verification
A job takes one cycle to be accepted. One response is then taken per cycle. The result appears exactly one cycle after the handshake of the last response. The bench drives every input on the falling edge and reads outputs on the next falling edge. It checks that out_valid is still low just before the last response, that it is high one edge after it, and that the result stays unchanged through any stall on out_ready. After the result is taken, idle is checked one edge later.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } isc_state_e;

    typedef enum logic {
        MODE_PROV  = 1'b0,
        MODE_REGEN = 1'b1
    } isc_mode_e;

    typedef struct packed {
        isc_mode_e mode;
        logic      data_bit;
    } isc_job_t;

    // Group size for a given select code and index width.
    function automatic int unsigned cand_count(input logic [1:0] sel, input int unsigned w);
        case (sel)
            2'b00:   return 32'd1 << (w - 1);
            2'b01:   return (32'd5 << (w - 1)) / 4;
            default: return 32'd1 << w;
        endcase
    endfunction

endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
    import isc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_valid,
    input  logic             start_mode,
    input  logic             start_bit,
    input  logic [1:0]       start_cfg,
    input  logic [IDX_W-1:0] start_index,
    input  logic             resp_valid,
    input  logic             out_ready,
    output logic             start_ready,
    output logic             resp_ready,
    output logic             out_valid,
    output logic             resp_fire,
    output logic             first,
    output logic [IDX_W-1:0] pos,
    output logic [IDX_W-1:0] idx_q,
    output isc_job_t         job_q
);
    localparam int CNT_W = IDX_W + 1;

    isc_state_e       state_q;
    logic [CNT_W-1:0] count_q;
    logic             last;

    assign start_ready = (state_q == ST_IDLE);
    assign resp_ready  = (state_q == ST_SCAN);
    assign out_valid   = (state_q == ST_DONE);
    assign resp_fire   = resp_valid && resp_ready;
    assign first       = (pos == '0);
    assign last        = ({1'b0, pos} == (count_q - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos     <= '0;
            count_q <= '0;
            idx_q   <= '0;
            job_q   <= '{mode: MODE_PROV, data_bit: 1'b0};
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_valid) begin
                        job_q   <= '{mode: isc_mode_e'(start_mode), data_bit: start_bit};
                        count_q <= CNT_W'(cand_count(start_cfg, IDX_W));
                        idx_q   <= start_index;
                        pos     <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (resp_valid) begin
                        pos <= pos + IDX_W'(1);
                        if (last) begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (out_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/isc_select.sv
module isc_select #(
    parameter int RESP_W     = 12,
    parameter int IDX_W      = 5,
    parameter bit TIE_RANDOM = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic                     first,
    input  logic [IDX_W-1:0]         pos,
    input  logic signed [RESP_W-1:0] resp,
    input  logic                     want_max,
    input  logic                     tie_rnd,
    output logic [IDX_W-1:0]         best_idx
);
    logic signed [RESP_W-1:0] best_q;
    logic                     beats;
    logic                     equal;
    logic                     tie_take;
    logic                     take;

    assign beats = want_max ? (resp > best_q) : (resp < best_q);
    assign equal = (resp == best_q);

    generate
        if (TIE_RANDOM) begin : g_tie_rnd
            assign tie_take = equal && tie_rnd;
        end else begin : g_tie_keep
            assign tie_take = 1'b0;
        end
    endgenerate

    assign take = first || beats || tie_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q   <= '0;
            best_idx <= '0;
        end else if (fire && take) begin
            best_q   <= resp;
            best_idx <= pos;
        end
    end

endmodule

// File: rtl/isc_regen.sv
module isc_regen #(
    parameter int RESP_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              first,
    input  logic [IDX_W-1:0]  pos,
    input  logic [RESP_W-1:0] resp,
    input  logic [IDX_W-1:0]  target,
    output logic              bit_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out <= 1'b0;
        end else if (fire) begin
            if (pos == target) begin
                bit_out <= ~resp[RESP_W-1];
            end else if (first) begin
                bit_out <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/isc_coder.sv
module isc_coder
    import isc_pkg::*;
#(
    parameter int RESP_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_valid,
    output logic                     start_ready,
    input  logic                     start_mode,
    input  logic                     start_bit,
    input  logic [1:0]               start_cfg,
    input  logic [IDX_W-1:0]         start_index,
    input  logic                     resp_valid,
    output logic                     resp_ready,
    input  logic signed [RESP_W-1:0] resp_data,
    input  logic                     tie_rnd,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [IDX_W-1:0]         out_index,
    output logic                     out_bit
);
    logic             resp_fire;
    logic             first;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] idx_q;
    isc_job_t         job_q;
    logic [IDX_W-1:0] best_idx;
    logic             regen_bit;

    isc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_valid (start_valid),
        .start_mode  (start_mode),
        .start_bit   (start_bit),
        .start_cfg   (start_cfg),
        .start_index (start_index),
        .resp_valid  (resp_valid),
        .out_ready   (out_ready),
        .start_ready (start_ready),
        .resp_ready  (resp_ready),
        .out_valid   (out_valid),
        .resp_fire   (resp_fire),
        .first       (first),
        .pos         (pos),
        .idx_q       (idx_q),
        .job_q       (job_q)
    );

    isc_select #(.RESP_W(RESP_W), .IDX_W(IDX_W), .TIE_RANDOM(1'b1)) u_select (
        .clk      (clk),
        .rst      (rst),
        .fire     (resp_fire),
        .first    (first),
        .pos      (pos),
        .resp     (resp_data),
        .want_max (job_q.data_bit),
        .tie_rnd  (tie_rnd),
        .best_idx (best_idx)
    );

    isc_regen #(.RESP_W(RESP_W), .IDX_W(IDX_W)) u_regen (
        .clk     (clk),
        .rst     (rst),
        .fire    (resp_fire),
        .first   (first),
        .pos     (pos),
        .resp    (resp_data),
        .target  (idx_q),
        .bit_out (regen_bit)
    );

    assign out_index = (job_q.mode == MODE_REGEN) ? idx_q : best_idx;
    assign out_bit   = (job_q.mode == MODE_REGEN) ? regen_bit : job_q.data_bit;

endmodule

// File: rtl/isc_coder_sva.sv
module isc_coder_sva
    import isc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start_valid,
    input logic             start_ready,
    input logic             start_mode,
    input logic [1:0]       start_cfg,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_index,
    input logic             out_bit
);
    logic [1:0]  cfg_c;
    logic        mode_c;
    int unsigned cnt_c;
    int unsigned exp_c;

    assign exp_c = cand_count(cfg_c, IDX_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_c  <= 2'b00;
            mode_c <= 1'b0;
            cnt_c  <= 0;
        end else if (start_valid && start_ready) begin
            cfg_c  <= start_cfg;
            mode_c <= start_mode;
            cnt_c  <= 0;
        end else if (resp_valid && resp_ready) begin
            cnt_c  <= cnt_c + 1;
        end
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (start_ready && !resp_ready && !out_valid));

    // R9: one phase at a time
    p_phase_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_ready, resp_ready, out_valid}));

    // R9: result one cycle after last response
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_ready && (cnt_c == exp_c - 1)) |=> out_valid);

    // R9: result held while stalled
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_bit)));

    // R5, R10: never accept beyond the group size sampled at start
    p_count_r10: assert property (@(posedge clk) disable iff (rst)
        resp_ready |-> (cnt_c < exp_c));

    // R5: provisioned index inside group
    p_index_range_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mode_c) |-> (32'(out_index) < exp_c));

endmodule

bind isc_coder isc_coder_sva #(.IDX_W(IDX_W)) u_sva (.*);

// File: tb/isc_coder_bench.sv
module isc_coder_bench;
    localparam int RESP_W = 12;
    localparam int IDX_W  = 5;
    localparam int NVEC   = 11;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start_valid = 1'b0;
    logic                     start_ready;
    logic                     start_mode = 1'b0;
    logic                     start_bit = 1'b0;
    logic [1:0]               start_cfg = 2'b00;
    logic [IDX_W-1:0]         start_index = '0;
    logic                     resp_valid = 1'b0;
    logic                     resp_ready;
    logic signed [RESP_W-1:0] resp_data = '0;
    logic                     tie_rnd = 1'b0;
    logic                     out_valid;
    logic                     out_ready = 1'b0;
    logic [IDX_W-1:0]         out_index;
    logic                     out_bit;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    logic signed [RESP_W-1:0] resp_buf [32];
    logic                     tie_buf  [32];

    // {mode, bit, cfg[1:0], idx[4:0], seed[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'b00, 5'd0,  8'd11},
        {1'b0, 1'b0, 2'b00, 5'd0,  8'd23},
        {1'b0, 1'b1, 2'b01, 5'd0,  8'd37},
        {1'b0, 1'b0, 2'b01, 5'd0,  8'd41},
        {1'b0, 1'b1, 2'b10, 5'd0,  8'd59},
        {1'b0, 1'b0, 2'b11, 5'd0,  8'd67},
        {1'b1, 1'b0, 2'b00, 5'd5,  8'd71},
        {1'b1, 1'b0, 2'b01, 5'd19, 8'd83},
        {1'b1, 1'b0, 2'b10, 5'd31, 8'd97},
        {1'b1, 1'b0, 2'b01, 5'd25, 8'd101},
        {1'b1, 1'b0, 2'b00, 5'd16, 8'd113}
    };

    isc_coder #(.RESP_W(RESP_W), .IDX_W(IDX_W)) u_isc_coder (.*);

    always #10 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int group_size(input logic [1:0] cfg);
        case (cfg)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 32;
        endcase
    endfunction

    task automatic fill_gen(input int seed);
        for (int p = 0; p < 32; p++) begin
            resp_buf[p] = RESP_W'(seed * 97 + p * 613 + ((p * p * seed) >> 2));
            tie_buf[p]  = ((seed + p) % 3) == 0;
        end
    endtask

    task automatic fill_const(input int v);
        for (int p = 0; p < 32; p++) begin
            resp_buf[p] = RESP_W'(v);
            tie_buf[p]  = 1'b0;
        end
    endtask

    function automatic int model_index(input bit b, input int n);
        int bi = 0;
        logic signed [RESP_W-1:0] best = resp_buf[0];
        for (int p = 1; p < n; p++) begin
            if ((b ? (resp_buf[p] > best) : (resp_buf[p] < best)) ||
                (resp_buf[p] == best && tie_buf[p])) begin
                best = resp_buf[p];
                bi   = p;
            end
        end
        return bi;
    endfunction

    task automatic run_block(input logic mode, input logic b, input logic [1:0] cfg,
                             input logic [4:0] idx, input int n, input bit flip_cfg,
                             input int hold, input string tag);
        int exp_idx;
        int exp_bit;
        if (mode) begin
            exp_idx = idx;
            exp_bit = (idx < n) ? int'(resp_buf[idx] >= 0) : 0;
        end else begin
            exp_idx = model_index(b, n);
            exp_bit = b;
        end
        @(negedge clk);
        start_valid = 1'b1; start_mode = mode; start_bit = b;
        start_cfg = cfg; start_index = idx;
        @(negedge clk);
        start_valid = 1'b0;
        if (flip_cfg) start_cfg = 2'b10;
        for (int p = 0; p < n; p++) begin
            if (p == n - 1)
                chk(!out_valid, {tag, " R9 early out_valid"}, out_valid, 0);
            resp_valid = 1'b1;
            resp_data  = resp_buf[p];
            tie_rnd    = tie_buf[p];
            @(negedge clk);
        end
        resp_valid = 1'b0;
        chk(out_valid, {tag, " R9 out_valid after last"}, out_valid, 1);
        chk(!resp_ready, {tag, " R5/R10 resp_ready after group"}, resp_ready, 0);
        chk(int'(out_index) == exp_idx, {tag, " index"}, out_index, exp_idx);
        chk(int'(out_bit) == exp_bit, {tag, mode ? " R7 bit" : " R11 bit"}, out_bit, exp_bit);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(out_valid && int'(out_index) == exp_idx, {tag, " R9 hold"}, out_index, exp_idx);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(start_ready && !out_valid, {tag, " R9 back to idle"}, start_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(start_ready == 1'b1, "R1 start_ready", start_ready, 1);
        chk(resp_ready == 1'b0, "R1 resp_ready", resp_ready, 0);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

        // Table: R2, R3, R5, R7, R8, R11
        for (int v = 0; v < NVEC; v++) begin
            fill_gen(int'(VEC[v][7:0]));
            run_block(VEC[v][16], VEC[v][15], VEC[v][14:13], VEC[v][12:8],
                      group_size(VEC[v][14:13]), 1'b0, 0,
                      $sformatf("vec%0d R2/R3/R5/R8", v));
        end

        // R4: signed comparison, -100 vs +3
        fill_const(-1);
        resp_buf[2] = -12'sd100;
        resp_buf[7] = 12'sd3;
        run_block(1'b0, 1'b1, 2'b00, 5'd0, 16, 1'b0, 0, "R4 max signed");
        chk(out_index == 5'd7 || 1'b0, "R4 max pos7", out_index, 7);
        run_block(1'b0, 1'b0, 2'b00, 5'd0, 16, 1'b0, 0, "R4 min signed");

        // R6: ties
        fill_const(5);
        tie_buf[3] = 1'b1;
        tie_buf[9] = 1'b1;
        run_block(1'b0, 1'b1, 2'b00, 5'd0, 16, 1'b0, 0, "R6 tie take");
        fill_const(5);
        run_block(1'b0, 1'b0, 2'b01, 5'd0, 20, 1'b0, 0, "R6 tie keep");

        // R7: both polarities
        fill_const(-5);
        run_block(1'b1, 1'b0, 2'b00, 5'd4, 16, 1'b0, 0, "R7 negative");
        fill_const(5);
        run_block(1'b1, 1'b0, 2'b10, 5'd30, 32, 1'b0, 0, "R7 positive");
        fill_const(0);
        run_block(1'b1, 1'b0, 2'b01, 5'd12, 20, 1'b0, 0, "R7 zero");

        // R10: cfg changes mid-scan; still 16 taken. R9 hold on stall.
        fill_gen(131);
        run_block(1'b0, 1'b1, 2'b00, 5'd0, 16, 1'b1, 3, "R10 cfg flip");

        summary();
        $finish;
    end

endmodule